// File: doc/BRIEF.md
# MII UDP Frame Transmitter

This block sends complete Ethernet frames that carry IPv4/UDP datagrams out of a 4-bit MII transmit port. The block runs entirely on the PHY transmit clock, and every register changes on that clock's falling edge. The addresses and ports are fixed when the design is built, through parameters, so the header is prepared in advance. The UDP checksum is sent as zero. Because of this, the payload passes through the block only once. The frame check sequence is built up nibble by nibble while the frame goes out, and it is appended at the end.

A user pulses or holds `start` while the block is idle. The block then latches `pay_len` and sends the frame. During the payload phase it pulls one byte every two clocks through `pay_ready`/`pay_valid`/`pay_data`. The sequencer has seven named states:

- IDLE: waits for `start`.
- PRE: sends the preamble and start delimiter.
- HDR: sends the 42 prepared header bytes.
- PAY: streams the payload.
- PAD: sends zero fill.
- FCS: sends the CRC trailer.
- GAP: enforces the inter-frame gap.

The transitions are:

- IDLE→PRE when `start` is seen.
- PRE→HDR after 16 nibbles.
- HDR→PAY after 84 nibbles when the length is non-zero; otherwise HDR→PAD.
- PAY→PAD when the payload is shorter than 18 bytes; otherwise PAY→FCS.
- PAD→FCS when the fill is complete.
- FCS→GAP after 8 nibbles.
- GAP→IDLE after `IFG_CYCLES` clocks.

Top module: `mii_udp_tx`

## Requirements
- R1: After reset, `mii_txen`, `mii_txd`, `busy` and `pay_ready` are all 0.
- R2: The first nibble of a frame appears two clocks after `start` is sampled in idle, and `mii_txen` rises with it. The frame opens with fifteen nibbles of 0x5 and then one nibble of 0xD.
- R3: Every byte after the delimiter is sent low nibble first. Payload bytes appear in the order they were accepted.
- R4: The header is sent in this byte order, with multi-byte fields most significant byte first:
  - destination MAC, then source MAC, then type 0x0800;
  - IPv4 header bytes 0x45, 0x00, total length, 0x0000, 0x0000, 0x40, 0x11, header checksum, source IP, destination IP;
  - UDP source port, destination port, UDP length, then checksum 0x0000.
- R5: For a payload of L bytes, the IPv4 total length is 28+L and the UDP length is 8+L. The header checksum is the inverted ones'-complement sum of the ten header words, with the checksum word taken as zero. L is the value of `pay_len` latched at frame start.
- R6: When L is below 18, zero bytes follow the payload so that destination MAC through fill is exactly 60 bytes. When L is 18 or more, no fill is sent.
- R7: The frame ends with the 32-bit FCS, sent as four bytes (eight nibbles), least significant nibble first:
  - it uses the reflected CRC-32 with polynomial 0x04C11DB7;
  - it starts from 0xFFFFFFFF, covers destination MAC through fill, and is inverted before it is sent.
  - `mii_txen` falls in the clock right after the last FCS nibble.
- R8: `pay_ready` is high only during the payload phase, for one clock out of every two, exactly L times per frame. A byte is taken in a clock where `pay_ready` is high.
- R9: If `pay_valid` is low in a clock where `pay_ready` is high, that byte position is sent as 0x00.
- R10: `busy` is high in the clock after `start` is accepted. It stays high during the first `IFG_CYCLES`-1 clocks in which `mii_txen` is low after a frame, and it is low in the next clock. `mii_txen` is never high while `busy` is low.
- R11: `start` has no effect while `busy` is high. A pulse during a frame produces no further frame.
- R12: With `start` held high, the next frame begins after exactly `IFG_CYCLES`+1 clocks with `mii_txen` low. The default of 24 therefore gives a gap of 25 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | PHY transmit clock; all state changes on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a frame; sampled only while idle |
| pay_len | input | LEN_W | Payload length in bytes, latched at frame start |
| pay_data | input | 8 | Payload byte |
| pay_valid | input | 1 | Payload byte present; a byte that is due while this is low is sent as zero |
| pay_ready | output | 1 | Payload byte taken in this clock |
| mii_txd | output | 4 | MII transmit nibble |
| mii_txen | output | 1 | MII transmit enable |
| busy | output | 1 | Frame or inter-frame gap in progress |

## Verification
A sequencer stuck in the wrong state or with the wrong nibble count shows up at once on `mii_txd`. The nibble stream shifts against the reference model, which is compared every clock. A bad length latch or a bad checksum is seen within the 84 header nibbles. A CRC register that is cleared or advanced in the wrong phase shows only in the last eight nibbles, but it is caught there in every frame. An error in the gap counter shows at the ports as the `busy` fall time or the back-to-back spacing, within about 25 clocks of the end of the frame.

// File: rtl/mii_udp_pkg.sv
package mii_udp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_PAY,
        ST_PAD,
        ST_FCS,
        ST_GAP
    } tx_state_t;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [31:0] CRC_SEED      = 32'hFFFFFFFF;

    // Advance a reflected CRC-32 by four data bits, bit 0 first.
    function automatic logic [31:0] crc_step_nibble(input logic [31:0] c_in,
                                                    input logic [3:0]  d);
        logic [31:0] c;
        c = c_in;
        for (int b = 0; b < 4; b++) begin
            if (c[0] ^ d[b])
                c = {1'b0, c[31:1]} ^ CRC_POLY_REFL;
            else
                c = {1'b0, c[31:1]};
        end
        return c;
    endfunction

endpackage

// File: rtl/mii_udp_hdr.sv
module mii_udp_hdr #(
    parameter int          LEN_W    = 11,
    parameter logic [47:0] DST_MAC  = 48'h02_00_00_00_00_02,
    parameter logic [47:0] SRC_MAC  = 48'h02_00_00_00_00_01,
    parameter logic [31:0] SRC_IP   = 32'hC0A8_0001,
    parameter logic [31:0] DST_IP   = 32'hC0A8_0002,
    parameter logic [15:0] SRC_PORT = 16'd4000,
    parameter logic [15:0] DST_PORT = 16'd5000
) (
    input  logic [LEN_W-1:0] len,
    input  logic [5:0]       byte_idx,
    output logic [7:0]       hdr_byte
);
    localparam int HDR_BYTES = 42;

    logic [15:0]            ip_total;
    logic [15:0]            udp_len;
    logic [31:0]            sum_raw;
    logic [16:0]            fold1;
    logic [16:0]            fold2;
    logic [15:0]            ip_csum;
    logic [HDR_BYTES*8-1:0] hdr_vec;
    int                     sel;

    always_comb begin
        ip_total = 16'(len) + 16'd28;
        udp_len  = 16'(len) + 16'd8;
        sum_raw  = 32'h4500 + 32'(ip_total) + 32'h4011
                 + 32'(SRC_IP[31:16]) + 32'(SRC_IP[15:0])
                 + 32'(DST_IP[31:16]) + 32'(DST_IP[15:0]);
        fold1    = 17'(sum_raw[15:0]) + 17'(sum_raw[31:16]);
        fold2    = 17'(fold1[15:0]) + 17'(fold1[16]);
        ip_csum  = ~fold2[15:0];
        hdr_vec  = {DST_MAC, SRC_MAC, 16'h0800,
                    8'h45, 8'h00, ip_total, 16'h0000, 16'h0000,
                    8'h40, 8'h11, ip_csum, SRC_IP, DST_IP,
                    SRC_PORT, DST_PORT, udp_len, 16'h0000};
        sel      = (int'(byte_idx) < HDR_BYTES) ? (HDR_BYTES - 1 - int'(byte_idx)) : 0;
        hdr_byte = hdr_vec[sel*8 +: 8];
    end

endmodule

// File: rtl/mii_udp_crc.sv
module mii_udp_crc
    import mii_udp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        advance,
    input  logic [3:0]  nib,
    output logic [31:0] crc
);
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)
            crc <= CRC_SEED;
        else if (clear)
            crc <= CRC_SEED;
        else if (advance)
            crc <= crc_step_nibble(crc, nib);
    end

endmodule

// File: rtl/mii_udp_tx.sv
module mii_udp_tx
    import mii_udp_pkg::*;
#(
    parameter int          MAX_LEN    = 1472,
    parameter int          IFG_CYCLES = 24,
    parameter int          LEN_W      = $clog2(MAX_LEN + 1),
    parameter logic [47:0] DST_MAC    = 48'h02_00_00_00_00_02,
    parameter logic [47:0] SRC_MAC    = 48'h02_00_00_00_00_01,
    parameter logic [31:0] SRC_IP     = 32'hC0A8_0001,
    parameter logic [31:0] DST_IP     = 32'hC0A8_0002,
    parameter logic [15:0] SRC_PORT   = 16'd4000,
    parameter logic [15:0] DST_PORT   = 16'd5000
) (
    input  logic             tx_clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] pay_len,
    input  logic [7:0]       pay_data,
    input  logic             pay_valid,
    output logic             pay_ready,
    output logic [3:0]       mii_txd,
    output logic             mii_txen,
    output logic             busy
);
    localparam int PRE_NIB = 16;
    localparam int HDR_NIB = 84;
    localparam int FCS_NIB = 8;
    localparam int MIN_PAY = 18;
    localparam int CNT_W   = $clog2(2 * MAX_LEN + HDR_NIB + IFG_CYCLES + 1);

    localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_NIB - 1);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_NIB - 1);
    localparam logic [CNT_W-1:0] FCS_LAST = CNT_W'(FCS_NIB - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(IFG_CYCLES - 1);
    localparam logic [LEN_W-1:0] MIN_LEN  = LEN_W'(MIN_PAY);

    tx_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [LEN_W-1:0] len_q;
    logic [3:0]       hi_q;
    logic [3:0]       nib_d;
    logic             en_d;
    logic             crc_clr, crc_adv;
    logic [7:0]       byte_in;
    logic [7:0]       hdr_byte;
    logic [31:0]      crc_q;
    logic [31:0]      crc_inv;
    logic [CNT_W-1:0] pay_nib, pad_nib;

    mii_udp_hdr #(
        .LEN_W(LEN_W), .DST_MAC(DST_MAC), .SRC_MAC(SRC_MAC),
        .SRC_IP(SRC_IP), .DST_IP(DST_IP),
        .SRC_PORT(SRC_PORT), .DST_PORT(DST_PORT)
    ) hdr_i (
        .len(len_q), .byte_idx(cnt_q[6:1]), .hdr_byte(hdr_byte)
    );

    mii_udp_crc crc_i (
        .clk(tx_clk), .rst_n(rst_n), .clear(crc_clr),
        .advance(crc_adv), .nib(nib_d), .crc(crc_q)
    );

    always_comb begin
        pay_nib = CNT_W'({len_q, 1'b0});
        pad_nib = (len_q < MIN_LEN) ? CNT_W'({MIN_LEN - len_q, 1'b0}) : '0;
        crc_inv = ~crc_q;
        byte_in = pay_valid ? pay_data : 8'h00;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (start) state_d = ST_PRE;
            end
            ST_PRE: if (cnt_q == PRE_LAST) begin
                cnt_d   = '0;
                state_d = ST_HDR;
            end
            ST_HDR: if (cnt_q == HDR_LAST) begin
                cnt_d   = '0;
                state_d = (len_q != '0) ? ST_PAY : ST_PAD;
            end
            ST_PAY: if (cnt_q == pay_nib - 1'b1) begin
                cnt_d   = '0;
                state_d = (pad_nib != '0) ? ST_PAD : ST_FCS;
            end
            ST_PAD: if (cnt_q == pad_nib - 1'b1) begin
                cnt_d   = '0;
                state_d = ST_FCS;
            end
            ST_FCS: if (cnt_q == FCS_LAST) begin
                cnt_d   = '0;
                state_d = ST_GAP;
            end
            ST_GAP: if (cnt_q == GAP_LAST) begin
                cnt_d   = '0;
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(negedge tx_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            len_q    <= '0;
            hi_q     <= '0;
            mii_txd  <= '0;
            mii_txen <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            mii_txd  <= nib_d;
            mii_txen <= en_d;
            if (state_q == ST_IDLE && start)
                len_q <= pay_len;
            if (state_q == ST_PAY && !cnt_q[0])
                hi_q <= byte_in[7:4];
        end
    end

    // Output logic
    always_comb begin
        nib_d     = 4'h0;
        en_d      = 1'b0;
        crc_clr   = 1'b0;
        crc_adv   = 1'b0;
        pay_ready = 1'b0;
        busy      = (state_q != ST_IDLE);
        unique case (state_q)
            ST_IDLE: crc_clr = 1'b1;
            ST_PRE: begin
                en_d    = 1'b1;
                crc_clr = 1'b1;
                nib_d   = (cnt_q == PRE_LAST) ? 4'hD : 4'h5;
            end
            ST_HDR: begin
                en_d    = 1'b1;
                crc_adv = 1'b1;
                nib_d   = cnt_q[0] ? hdr_byte[7:4] : hdr_byte[3:0];
            end
            ST_PAY: begin
                en_d      = 1'b1;
                crc_adv   = 1'b1;
                pay_ready = !cnt_q[0];
                nib_d     = cnt_q[0] ? hi_q : byte_in[3:0];
            end
            ST_PAD: begin
                en_d    = 1'b1;
                crc_adv = 1'b1;
            end
            ST_FCS: begin
                en_d  = 1'b1;
                nib_d = crc_inv[int'(cnt_q[2:0]) * 4 +: 4];
            end
            ST_GAP: ;
        endcase
    end

endmodule

// File: rtl/mii_udp_tx_chk.sv
module mii_udp_tx_chk #(
    parameter int IFG_CYCLES = 24
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       txen,
    input logic [3:0] txd,
    input logic       ready
);
    localparam int RUN_W = $clog2(IFG_CYCLES + 2);

    logic [RUN_W-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_run <= RUN_W'(IFG_CYCLES);
        else if (txen)
            low_run <= '0;
        else if (low_run < RUN_W'(IFG_CYCLES))
            low_run <= low_run + 1'b1;
    end

    // R2
    preamble_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txen) |-> txd == 4'h5);

    // R8
    ready_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R8
    ready_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (txen && busy));

    // R10
    txen_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txen |-> busy);

    // R10
    gap_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txen) |-> busy);

    // R12
    gap_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txen) |-> low_run >= RUN_W'(IFG_CYCLES));

endmodule

bind mii_udp_tx mii_udp_tx_chk #(.IFG_CYCLES(IFG_CYCLES)) chk_i (
    .clk(tx_clk), .rst_n(rst_n), .busy(busy),
    .txen(mii_txen), .txd(mii_txd), .ready(pay_ready)
);

// File: tb/mii_udp_tx_tb_top.sv
module mii_udp_tx_tb_top;
    localparam int          IFG      = 24;
    localparam int          LW       = 11;
    localparam logic [47:0] T_DMAC   = 48'h02_11_22_33_44_55;
    localparam logic [47:0] T_SMAC   = 48'h02_AA_BB_CC_DD_EE;
    localparam logic [31:0] T_SIP    = 32'h0A00_0001;
    localparam logic [31:0] T_DIP    = 32'h0A00_00FE;
    localparam logic [15:0] T_SPORT  = 16'h1234;
    localparam logic [15:0] T_DPORT  = 16'hABCD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [LW-1:0] pay_len = '0;
    logic [7:0]    pay_data = '0;
    logic          pay_valid = 1'b0;
    logic          pay_ready;
    logic [3:0]    mii_txd;
    logic          mii_txen;
    logic          busy;

    int checks = 0;
    int errors = 0;
    int low_run = 0;
    int last_gap = 0;
    int mid_start_at = -1;
    int exp_nib[$];
    string exp_tag[$];
    byte unsigned pay_mem[0:63];

    always #2 clk = ~clk;

    mii_udp_tx #(
        .MAX_LEN(1472), .IFG_CYCLES(IFG),
        .DST_MAC(T_DMAC), .SRC_MAC(T_SMAC), .SRC_IP(T_SIP), .DST_IP(T_DIP),
        .SRC_PORT(T_SPORT), .DST_PORT(T_DPORT)
    ) dut_i (
        .tx_clk(clk), .rst_n(rst_n), .start(start), .pay_len(pay_len),
        .pay_data(pay_data), .pay_valid(pay_valid), .pay_ready(pay_ready),
        .mii_txd(mii_txd), .mii_txen(mii_txen), .busy(busy)
    );

    // Length of low-enable runs between frames
    always @(posedge clk) begin
        if (rst_n) begin
            if (!mii_txen) low_run++;
            else begin
                if (low_run > 0) last_gap = low_run;
                low_run = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, expv, $time);
        end
    endtask

    // Reference frame as a nibble stream
    task automatic build_frame(input int len, input int drop);
        byte unsigned fr[$];
        int sum;
        int body;
        logic [31:0] crc;
        fr = {};
        for (int i = 5; i >= 0; i--) fr.push_back(T_DMAC[i*8 +: 8]);
        for (int i = 5; i >= 0; i--) fr.push_back(T_SMAC[i*8 +: 8]);
        fr.push_back(8'h08); fr.push_back(8'h00);
        fr.push_back(8'h45); fr.push_back(8'h00);
        fr.push_back(8'((28 + len) >> 8)); fr.push_back(8'(28 + len));
        for (int i = 0; i < 4; i++) fr.push_back(8'h00);
        fr.push_back(8'h40); fr.push_back(8'h11);
        fr.push_back(8'h00); fr.push_back(8'h00);
        for (int i = 3; i >= 0; i--) fr.push_back(T_SIP[i*8 +: 8]);
        for (int i = 3; i >= 0; i--) fr.push_back(T_DIP[i*8 +: 8]);
        fr.push_back(T_SPORT[15:8]); fr.push_back(T_SPORT[7:0]);
        fr.push_back(T_DPORT[15:8]); fr.push_back(T_DPORT[7:0]);
        fr.push_back(8'((8 + len) >> 8)); fr.push_back(8'(8 + len));
        fr.push_back(8'h00); fr.push_back(8'h00);
        sum = 0;
        for (int w = 0; w < 10; w++) sum += (int'(fr[14 + 2*w]) << 8) + int'(fr[15 + 2*w]);
        while (sum > 16'hFFFF) sum = (sum & 16'hFFFF) + (sum >> 16);
        sum = ~sum & 16'hFFFF;
        fr[24] = 8'(sum >> 8);
        fr[25] = 8'(sum);
        for (int k = 0; k < len; k++) fr.push_back((k == drop) ? 8'h00 : pay_mem[k]);
        body = 42 + len;
        while (body < 60) begin fr.push_back(8'h00); body++; end
        crc = 32'hFFFFFFFF;
        foreach (fr[i])
            for (int j = 0; j < 8; j++)
                crc = ((crc[0] ^ fr[i][j]) != 1'b0) ? ((crc >> 1) ^ 32'hEDB88320) : (crc >> 1);
        crc = ~crc;
        exp_nib = {};
        exp_tag = {};
        for (int i = 0; i < 15; i++) begin exp_nib.push_back(5); exp_tag.push_back("R2"); end
        exp_nib.push_back(13); exp_tag.push_back("R2");
        foreach (fr[i]) begin
            string t;
            if (i < 42)
                t = (i == 16 || i == 17 || i == 24 || i == 25 || i == 38 || i == 39) ? "R5" : "R4";
            else if (i < 42 + len)
                t = (i - 42 == drop) ? "R9" : "R3";
            else
                t = "R6";
            exp_nib.push_back(int'(fr[i][3:0])); exp_tag.push_back(t);
            exp_nib.push_back(int'(fr[i][7:4])); exp_tag.push_back(t);
        end
        for (int i = 0; i < 8; i++) begin
            exp_nib.push_back(int'(crc[i*4 +: 4]));
            exp_tag.push_back("R7");
        end
    endtask

    // Drive one frame and compare every clock; called at a rising edge
    task automatic run_frame(input int len, input int drop, input bit hold);
        int k;
        int rdy;
        int bcnt;
        for (int i = 0; i < 64; i++) pay_mem[i] = 8'((i * 37 + len * 11 + 3) & 8'hFF);
        build_frame(len, drop);
        pay_len = LW'(len);
        start = 1'b1;
        @(posedge clk);
        chk(busy === 1'b1, "R10 busy after start", int'(busy), 1);
        if (!hold) start = 1'b0;
        @(posedge clk);
        chk(mii_txen === 1'b1, "R2 enable with first nibble", int'(mii_txen), 1);
        k = 0;
        rdy = 0;
        for (int i = 0; i < exp_nib.size(); i++) begin
            chk(mii_txen === 1'b1, {exp_tag[i], " enable"}, int'(mii_txen), 1);
            chk(int'(mii_txd) == exp_nib[i], {exp_tag[i], " nibble"}, int'(mii_txd), exp_nib[i]);
            if (i == mid_start_at) start = 1'b1;
            if (i == mid_start_at + 2) start = 1'b0;
            if (pay_ready) begin
                rdy++;
                pay_valid = (k != drop);
                pay_data = (k < 64) ? pay_mem[k] : 8'h00;
                k++;
            end else begin
                pay_valid = 1'b0;
            end
            if (i < exp_nib.size() - 1) @(posedge clk);
        end
        @(posedge clk);
        pay_valid = 1'b0;
        chk(rdy == len, "R8 ready count", rdy, len);
        chk(mii_txen === 1'b0, "R7 enable low after FCS", int'(mii_txen), 0);
        bcnt = 0;
        while (busy && bcnt < 200) begin
            bcnt++;
            chk(mii_txen === 1'b0, "R10 enable low in gap", int'(mii_txen), 0);
            @(posedge clk);
        end
        chk(bcnt == IFG - 1, "R10 busy length in gap", bcnt, IFG - 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        chk(mii_txen === 1'b0, "R1 txen", int'(mii_txen), 0);
        chk(mii_txd === 4'h0, "R1 txd", int'(mii_txd), 0);
        chk(busy === 1'b0, "R1 busy", int'(busy), 0);
        chk(pay_ready === 1'b0, "R1 ready", int'(pay_ready), 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);

        run_frame(5, -1, 1'b0);
        repeat (3) @(posedge clk);
        run_frame(0, -1, 1'b0);
        repeat (2) @(posedge clk);
        run_frame(18, -1, 1'b0);
        repeat (2) @(posedge clk);

        // Underrun byte and a start pulse in mid-frame
        mid_start_at = 120;
        run_frame(40, 7, 1'b0);
        mid_start_at = -1;
        for (int i = 0; i < 40; i++) begin
            chk(mii_txen === 1'b0 && busy === 1'b0, "R11 no extra frame",
                int'({busy, mii_txen}), 0);
            @(posedge clk);
        end

        // Back-to-back frames with start held
        run_frame(20, -1, 1'b1);
        run_frame(3, -1, 1'b0);
        chk(last_gap == IFG + 1, "R12 gap between frames", last_gap, IFG + 1);

        repeat (5) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule